// File: doc/BRIEF.md
# Dual Edge Event Counter

This block counts transitions on two external event inputs. Each input is brought into the system clock domain by a short flop chain, then passed to an edge detector whose active edge (rising or falling) is chosen in software. Every detected edge advances a 16-bit counter that belongs to that input. A single control byte picks the edge of each input, can join the two counters into one 32-bit counter fed only by the first input, and requests a snapshot.

Software reaches the block through a plain byte-wide register port: an address, write data, a one-cycle write strobe and combinational read data. Counter bytes are written directly to preset or clear a count. Reads of counter bytes never see the live count. They return a holding copy taken, all four bytes at once, when the snapshot bit goes from 0 to 1, so a multi-byte value read over several accesses always belongs together.

Top module: `dual_edge_counter`

## Requirements
- R1: After reset both counters, the control register and the holding copy are zero, and every register offset reads 0x00.
- R2: With its edge-select bit at 0 (bit 0 for input A, bit 1 for input B of the control register at offset 0x0C), a counter advances by exactly one for each low-to-high transition of its input and not on the high-to-low transition.
- R3: With its edge-select bit at 1, a counter advances by exactly one for each high-to-low transition and not on the low-to-high transition.
- R4: Outside cascade mode each 16-bit counter wraps from 0xFFFF to 0x0000, and the wrap does not change the other counter.
- R5: With control bit 2 set, the four bytes form one 32-bit count (A low byte at 0x0D as least significant, then 0x0E, 0x0F, 0x10) that input A advances, carrying from bit 15 into bit 16; input B then has no effect.
- R6: A write to 0x0C that takes bit 3 from 0 to 1 copies all four live count bytes into the holding copy; reads of 0x0D to 0x10 return the holding copy, which keeps its value while counting continues until the next 0-to-1 write of bit 3.
- R7: A write to one of 0x0D (A low), 0x0E (A high), 0x0F (B low) or 0x10 (B high) loads that byte of the live count and leaves the other three bytes unchanged.
- R8: An edge whose count would land in the same clock cycle as a write strobe to a counter byte is discarded, not postponed.
- R9: Offset 0x0C reads back the four written control bits in bits 3:0 with bits 7:4 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_a | input | 1 | Event input A, asynchronous to clk |
| evt_b | input | 1 | Event input B, asynchronous to clk |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr |

## Verification
The bench aims at the wrap from 0xFFFF, where a counter that leaked a carry into its neighbour or stuck at the top would show the wrong pair of values, and at the cascade carry from bit 15 to 16, which a design ignoring the chain bit would miss while still counting input B. It checks that the holding copy stays frozen while new edges arrive, which catches reads wired to the live count. It places an edge in exactly the cycle of a counter-byte write to show that a design which defers or keeps the edge ends one count high, and it checks the opposite edge of each polarity to catch a detector that counts both transitions.

// File: rtl/evc_pkg.sv
package evc_pkg;
   // Register offsets used by the software view of the block
   localparam int unsigned CTRL_OFF = 'h0C;
   localparam int unsigned CNT_OFF  = 'h0D;
   // Control bit positions
   localparam int unsigned BIT_POL_A = 0;
   localparam int unsigned BIT_POL_B = 1;
   localparam int unsigned BIT_CHAIN = 2;
   localparam int unsigned BIT_SNAP  = 3;
   localparam int unsigned CTRL_W    = 4;

   typedef struct packed {
      logic snap;
      logic chain;
      logic pol_b;
      logic pol_a;
   } evc_ctrl_t;
endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic pol_fall,
   output logic edge_hit
);
   initial begin
      if (STAGES < 2) $error("evc_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              level;

   assign level = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= level;
      end
   end

   assign edge_hit = pol_fall ? (prev_q & ~level) : (level & ~prev_q);
endmodule

// File: rtl/evc_counter_core.sv
module evc_counter_core #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned TOT_W = 2 * CNT_W,
   localparam int unsigned NBYTE = TOT_W / BYTE_W,
   localparam int unsigned IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        edge_hit,
   input  logic              chain,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [BYTE_W-1:0] ld_data,
   output logic [TOT_W-1:0]  count
);
   logic [TOT_W-1:0] cnt_q;
   logic [TOT_W-1:0] next_run;

   always_comb begin
      next_run = cnt_q;
      if (chain) begin
         if (edge_hit[0]) next_run = cnt_q + TOT_W'(1);
      end else begin
         if (edge_hit[0]) next_run[CNT_W-1:0]     = cnt_q[CNT_W-1:0] + CNT_W'(1);
         if (edge_hit[1]) next_run[TOT_W-1:CNT_W] = cnt_q[TOT_W-1:CNT_W] + CNT_W'(1);
      end
   end

   for (genvar gi = 0; gi < NBYTE; gi++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[gi*BYTE_W +: BYTE_W] <= '0;
         else if (ld_en)
            cnt_q[gi*BYTE_W +: BYTE_W] <= (ld_idx == IDX_W'(gi)) ? ld_data
                                          : cnt_q[gi*BYTE_W +: BYTE_W];
         else
            cnt_q[gi*BYTE_W +: BYTE_W] <= next_run[gi*BYTE_W +: BYTE_W];
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/evc_regs.sv
module evc_regs
   import evc_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned TOT_W = 2 * CNT_W,
   localparam int unsigned NBYTE = TOT_W / BYTE_W,
   localparam int unsigned IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              reg_wr,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic [TOT_W-1:0]  live,
   output evc_ctrl_t         ctrl,
   output logic              ld_en,
   output logic [IDX_W-1:0]  ld_idx,
   output logic [TOT_W-1:0]  held
);
   logic              in_cnt;
   logic              at_ctrl;
   logic [ADDR_W-1:0] rel;
   evc_ctrl_t         ctrl_q;
   evc_ctrl_t         ctrl_nx;
   logic [TOT_W-1:0]  held_q;

   assign at_ctrl = (reg_addr == ADDR_W'(CTRL_OFF));
   assign rel     = reg_addr - ADDR_W'(CNT_OFF);
   assign in_cnt  = (reg_addr >= ADDR_W'(CNT_OFF)) && (rel < ADDR_W'(NBYTE));
   assign ld_en   = reg_wr && in_cnt;
   assign ld_idx  = rel[IDX_W-1:0];
   assign ctrl_nx = evc_ctrl_t'(reg_wdata[CTRL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         held_q <= '0;
      end else if (reg_wr && at_ctrl) begin
         ctrl_q <= ctrl_nx;
         if (ctrl_nx.snap && !ctrl_q.snap) held_q <= live;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (at_ctrl)
         reg_rdata = BYTE_W'(ctrl_q);
      else if (in_cnt)
         reg_rdata = held_q[ld_idx*BYTE_W +: BYTE_W];
   end

   assign ctrl = ctrl_q;
   assign held = held_q;
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter
   import evc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned TOT_W = 2 * CNT_W,
   localparam int unsigned NBYTE = TOT_W / BYTE_W,
   localparam int unsigned IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_a,
   input  logic              evt_b,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              reg_wr,
   output logic [BYTE_W-1:0] reg_rdata
);
   initial begin
      if (CNT_W % BYTE_W != 0) $error("dual_edge_counter: CNT_W must be a multiple of BYTE_W");
      if (BYTE_W < CTRL_W) $error("dual_edge_counter: BYTE_W too narrow for control");
      if ((1 << ADDR_W) < CNT_OFF + NBYTE) $error("dual_edge_counter: ADDR_W too small");
   end

   evc_ctrl_t        ctrl;
   logic [1:0]       edge_v;
   logic [1:0]       evt_v;
   logic [1:0]       pol_v;
   logic             ld_en;
   logic [IDX_W-1:0] ld_idx;
   logic [TOT_W-1:0] live_q;
   logic [TOT_W-1:0] held_q;

   assign evt_v = {evt_b, evt_a};
   assign pol_v = {ctrl.pol_b, ctrl.pol_a};

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      evc_sync_edge #(.STAGES(SYNC_STAGES)) u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .din      (evt_v[ch]),
         .pol_fall (pol_v[ch]),
         .edge_hit (edge_v[ch])
      );
   end

   evc_counter_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_hit (edge_v),
      .chain    (ctrl.chain),
      .ld_en    (ld_en),
      .ld_idx   (ld_idx),
      .ld_data  (reg_wdata),
      .count    (live_q)
   );

   evc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rdata (reg_rdata),
      .live      (live_q),
      .ctrl      (ctrl),
      .ld_en     (ld_en),
      .ld_idx    (ld_idx),
      .held      (held_q)
   );
endmodule

// File: rtl/evc_checker.sv
module evc_checker
   import evc_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned TOT_W = 2 * CNT_W,
   localparam int unsigned NBYTE = TOT_W / BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [BYTE_W-1:0] reg_wdata,
   input logic              reg_wr,
   input logic [1:0]        edge_v,
   input logic              chain,
   input logic [TOT_W-1:0]  live,
   input logic [TOT_W-1:0]  held
);
   logic cnt_write;
   assign cnt_write = reg_wr && (reg_addr >= ADDR_W'(CNT_OFF))
                      && (reg_addr < ADDR_W'(CNT_OFF + NBYTE));

   // R2: a detected edge is a single-cycle pulse
   a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      edge_v[0] |=> !edge_v[0]);

   // R4: an unchained edge on A adds exactly one to the low counter
   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain && edge_v[0] && !cnt_write) |=>
      live[CNT_W-1:0] == CNT_W'($past(live[CNT_W-1:0]) + 1'b1));

   // R5: when chained, input B alone changes nothing
   a_r5_b_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (chain && !edge_v[0] && !cnt_write) |=> $stable(live));

   // R6: the holding copy moves only on a control write
   a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == ADDR_W'(CTRL_OFF)) |=> $stable(held));

   // R7: a write to the lowest counter byte loads it
   a_r7_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(CNT_OFF)) |=> live[BYTE_W-1:0] == $past(reg_wdata));

   // R8: during a write to another counter byte the lowest byte cannot count
   a_r8_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(CNT_OFF + 1)) |=> $stable(live[BYTE_W-1:0]));
endmodule

bind dual_edge_counter evc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_wr    (reg_wr),
   .edge_v    (edge_v),
   .chain     (ctrl.chain),
   .live      (live_q),
   .held      (held_q)
);

// File: tb/dual_edge_counter_test.sv
module dual_edge_counter_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_a = 1'b0;
   logic       evt_b = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] ctrl_cur = 8'h00;

   dual_edge_counter uut (
      .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
      .reg_rdata(reg_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_ctrl(input logic [7:0] v);
      ctrl_cur = v & 8'h07;
      wr(5'h0C, ctrl_cur);
   endtask

   task automatic snap();
      wr(5'h0C, ctrl_cur);
      wr(5'h0C, ctrl_cur | 8'h08);
   endtask

   task automatic rd16(input logic [4:0] a, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(a, lo); rd(a + 5'd1, hi);
      v = {hi, lo};
   endtask

   task automatic load(input bit ch_b, input logic [15:0] v);
      logic [4:0] base;
      base = ch_b ? 5'h0F : 5'h0D;
      wr(base, v[7:0]); wr(base + 5'd1, v[15:8]);
   endtask

   task automatic pulse(input bit ch_b);
      @(negedge clk);
      if (ch_b) evt_b = 1'b1; else evt_a = 1'b1;
      repeat (4) @(negedge clk);
      if (ch_b) evt_b = 1'b0; else evt_a = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 'h0C; a <= 'h10; a++) begin
         rd(5'(a), d);
         check("R1 reset read", {24'h0, d}, 32'h0);
      end
   endtask

   task automatic t_ctrl_readback();
      logic [7:0] d;
      wr(5'h0C, 8'hF5);
      rd(5'h0C, d);
      check("R9 control readback", {24'h0, d}, 32'h05);
      set_ctrl(8'h00);
      rd(5'h0C, d);
      check("R9 control cleared", {24'h0, d}, 32'h00);
   endtask

   task automatic t_rising();
      logic [15:0] a, b;
      set_ctrl(8'h00);
      load(0, 16'h0000); load(1, 16'h0000);
      pulse(0); pulse(1); pulse(1);
      snap(); rd16(5'h0D, a); rd16(5'h0F, b);
      check("R2 rising A", {16'h0, a}, 32'h1);
      check("R2 rising B", {16'h0, b}, 32'h2);
   endtask

   task automatic t_falling();
      logic [15:0] a;
      set_ctrl(8'h03);
      load(0, 16'h0100);
      @(negedge clk); evt_a = 1'b1;
      repeat (5) @(negedge clk);
      snap(); rd16(5'h0D, a);
      check("R3 no count on rise", {16'h0, a}, 32'h0100);
      evt_a = 1'b0;
      repeat (5) @(negedge clk);
      snap(); rd16(5'h0D, a);
      check("R3 count on fall", {16'h0, a}, 32'h0101);
   endtask

   task automatic t_wrap();
      logic [15:0] a, b;
      set_ctrl(8'h00);
      load(0, 16'hFFFF); load(1, 16'h0012);
      pulse(0);
      snap(); rd16(5'h0D, a); rd16(5'h0F, b);
      check("R4 wrap A", {16'h0, a}, 32'h0000);
      check("R4 B untouched", {16'h0, b}, 32'h0012);
   endtask

   task automatic t_cascade();
      logic [15:0] a, b;
      set_ctrl(8'h04);
      load(0, 16'hFFFF); load(1, 16'h0012);
      pulse(0);
      snap(); rd16(5'h0D, a); rd16(5'h0F, b);
      check("R5 chained carry", {b, a}, 32'h0013_0000);
      pulse(1);
      snap(); rd16(5'h0D, a); rd16(5'h0F, b);
      check("R5 input B ignored", {b, a}, 32'h0013_0000);
      pulse(0);
      snap(); rd16(5'h0D, a); rd16(5'h0F, b);
      check("R5 chained step", {b, a}, 32'h0013_0001);
      set_ctrl(8'h00);
   endtask

   task automatic t_snapshot();
      logic [15:0] a;
      set_ctrl(8'h00);
      load(0, 16'h0010);
      snap();
      pulse(0); pulse(0);
      rd16(5'h0D, a);
      check("R6 holding copy frozen", {16'h0, a}, 32'h0010);
      snap(); rd16(5'h0D, a);
      check("R6 new snapshot", {16'h0, a}, 32'h0012);
   endtask

   task automatic t_byte_load();
      logic [15:0] a, b;
      set_ctrl(8'h00);
      load(0, 16'h5566); load(1, 16'hABCD);
      wr(5'h0F, 8'h34);
      snap(); rd16(5'h0D, a); rd16(5'h0F, b);
      check("R7 single byte load", {16'h0, b}, 32'hAB34);
      check("R7 other counter kept", {16'h0, a}, 32'h5566);
   endtask

   task automatic t_drop();
      logic [15:0] a;
      set_ctrl(8'h00);
      load(0, 16'h0005);
      repeat (3) @(negedge clk);
      evt_a = 1'b1;
      @(posedge clk); @(posedge clk);
      wr(5'h0E, 8'h00);   // strobe lands on the counting edge
      repeat (4) @(negedge clk);
      evt_a = 1'b0;
      repeat (4) @(negedge clk);
      snap(); rd16(5'h0D, a);
      check("R8 edge dropped during write", {16'h0, a}, 32'h0005);
      pulse(0);
      snap(); rd16(5'h0D, a);
      check("R8 counting resumes", {16'h0, a}, 32'h0006);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_ctrl_readback();
      t_rising();
      t_falling();
      t_wrap();
      t_cascade();
      t_snapshot();
      t_byte_load();
      t_drop();
      report();
   end
endmodule